// File: doc/BRIEF.md
# Line and Frame Sync Generator

This block derives the line and frame timing of a progressive-scan image sensor from the master clock. A pixel-clock counter walks through each line and a line counter walks through each frame. From these two counts the block produces an active-low line sync pulse at the start of every line and an active-low frame sync that covers the whole first line of each frame. Both counters are also brought out for the pulse-generation logic that shapes the sensor drive waveforms. A one-cycle strobe marks the first clock of each new frame.

Two readout modes set the frame height. Full mode reads every line, so the frame is tall. Draft mode decimates the lines, so the frame is one third as tall and the frame rate is three times higher. The requested mode is not applied at once. It is taken only at the line boundary that opens the readout line, so a frame never changes length in the middle of its exposure. A sync-disable input and a standby input each stop the generator and hold both sync outputs low. Standby has the higher priority. Reset has the same effect on the outputs.

Top module: `sync_tgen`

## Requirements
- R1: While `rst_n` is low, `line_sync_n`, `frame_sync_n`, `frame_start`, `pix_cnt` and `line_cnt` are all 0, and the active mode is draft.
- R2: While running, `pix_cnt` counts 0 to LINE_CLKS-1 and then wraps to 0. `line_cnt` advances by one on that wrap.
- R3: `line_sync_n` is low while `pix_cnt` is below HS_WIDTH, which gives a low pulse of HS_WIDTH clocks per line. It is high for the rest of the line.
- R4: `frame_sync_n` is low while `line_cnt` is 0, which gives LINE_CLKS clocks per frame, and high on every other line.
- R5: A frame in draft mode has DRAFT_LINES lines (`line_cnt` peaks at DRAFT_LINES-1). A frame in full mode has FULL_LINES lines.
- R6: `full_mode` (1 = full, 0 = draft) is sampled only at the wrap from line RD_LINE-1 into line RD_LINE. A change at any other time has no effect on the frame in progress.
- R7: `frame_start` is high for exactly one clock, the clock in which `line_cnt` and `pix_cnt` are both 0 after a wrap from the last line. It is low at all other times.
- R8: While `sync_off` is 1, both counters are held at 0 and both sync outputs are low. After release, counting starts again from line 0, pixel 0.
- R9: While `standby` is 1, the outputs are forced low and the counters are cleared, whatever the value of `sync_off`. With both set, dropping `standby` alone keeps the block stopped.
- R10: The sync outputs are registered on the falling clock edge. They therefore follow a counter change half a clock later, not at the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| full_mode | input | 1 | Requested readout mode: 1 = full, 0 = draft |
| sync_off | input | 1 | Stops the generator and forces the sync outputs low |
| standby | input | 1 | Standby state; same effect as sync_off and dominates it |
| line_sync_n | output | 1 | Line sync, active low, HS_WIDTH clocks per line |
| frame_sync_n | output | 1 | Frame sync, active low during line 0 |
| line_cnt | output | clog2(max lines) | Current line within the frame |
| pix_cnt | output | clog2(LINE_CLKS) | Current pixel clock within the line |
| frame_start | output | 1 | One-cycle strobe at the first clock of a frame |

## Verification
The bench shortens the line and frame lengths so that several complete frames fit into the run. A cycle-by-cycle model then follows every counter and output, with the mode held steady in draft and then in full, so that each frame height is checked by its peak line number. The mode bit is changed just after the sampling line and late in a frame. The first case shows that the current frame keeps its length. The second shows that the switch lands exactly one frame later. The disable and standby inputs are raised mid-line, alone and together, with standby dropped first. This separates clearing from pausing and shows which input dominates. One probe just after a rising edge catches outputs that would move on the wrong edge.

// File: rtl/sync_tgen_pkg.sv
package sync_tgen_pkg;

    typedef enum logic [1:0] {
        GEN_RUN  = 2'd0,
        GEN_OFF  = 2'd1,
        GEN_STBY = 2'd2
    } gen_state_e;

    // standby dominates the sync-disable request
    function automatic gen_state_e pick_state(input logic stby, input logic off);
        gen_state_e st;
        if (stby)     st = GEN_STBY;
        else if (off) st = GEN_OFF;
        else          st = GEN_RUN;
        return st;
    endfunction

endpackage

// File: rtl/sync_pix_ctr.sv
module sync_pix_ctr #(
    parameter int LINE_CLKS = 1270,
    parameter int PIX_W     = $clog2(LINE_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [PIX_W-1:0] pix,
    output logic             line_end
);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_CLKS - 1);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
    } pix_state_t;

    pix_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run)
            s_d.pix = '0;
        else if (s_q.pix == PIX_LAST)
            s_d.pix = '0;
        else
            s_d.pix = s_q.pix + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pix      = s_q.pix;
    assign line_end = run && (s_q.pix == PIX_LAST);

    // R2
    pix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pix <= PIX_LAST);

    // R8
    pix_halt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.pix == '0));

endmodule

// File: rtl/sync_line_ctr.sv
module sync_line_ctr #(
    parameter int FULL_LINES  = 792,
    parameter int DRAFT_LINES = 264,
    parameter int RD_LINE     = 7,
    parameter int LINE_W      = $clog2(FULL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              line_end,
    input  logic              full_req,
    output logic [LINE_W-1:0] line,
    output logic              frame_start,
    output logic              full_act
);
    localparam logic [LINE_W-1:0] FULL_LAST  = LINE_W'(FULL_LINES - 1);
    localparam logic [LINE_W-1:0] DRAFT_LAST = LINE_W'(DRAFT_LINES - 1);
    localparam logic [LINE_W-1:0] RD_PREV    = LINE_W'(RD_LINE - 1);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              frame_start;
        logic              full_act;
    } line_state_t;

    line_state_t s_d, s_q;
    logic [LINE_W-1:0] last_line;

    always_comb begin
        last_line     = s_q.full_act ? FULL_LAST : DRAFT_LAST;
        s_d           = s_q;
        s_d.frame_start = 1'b0;
        if (!run) begin
            s_d.line = '0;
        end else if (line_end) begin
            if (s_q.line == last_line) begin
                s_d.line        = '0;
                s_d.frame_start = 1'b1;
            end else begin
                s_d.line = s_q.line + 1'b1;
            end
            // mode request taken only when entering the readout line
            if (s_q.line == RD_PREV)
                s_d.full_act = full_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line        = s_q.line;
    assign frame_start = s_q.frame_start;
    assign full_act    = s_q.full_act;

    // R5
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.line <= FULL_LAST) && (s_q.full_act || (s_q.line <= DRAFT_LAST)));

    // R6
    mode_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full_act != $past(s_q.full_act)) |-> $past(line_end && (s_q.line == RD_PREV)));

    // R7
    frame_start_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.frame_start |-> (s_q.line == '0));

    // R7
    frame_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.frame_start |=> !s_q.frame_start);

endmodule

// File: rtl/sync_out_stage.sv
module sync_out_stage
    import sync_tgen_pkg::*;
#(
    parameter int HS_WIDTH = 32,
    parameter int PIX_W    = 11,
    parameter int LINE_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gen_state_e        state,
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    output logic              line_sync_n,
    output logic              frame_sync_n
);
    localparam logic [PIX_W-1:0] HS_LIM = PIX_W'(HS_WIDTH);

    typedef struct packed {
        logic ls_n;
        logic fs_n;
    } out_state_t;

    out_state_t s_d, s_q;

    always_comb begin
        if (state != GEN_RUN) begin
            s_d.ls_n = 1'b0;
            s_d.fs_n = 1'b0;
        end else begin
            s_d.ls_n = (pix >= HS_LIM);
            s_d.fs_n = (line != '0);
        end
    end

    // outputs launched on the falling edge, half a clock after the counters
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line_sync_n  = s_q.ls_n;
    assign frame_sync_n = s_q.fs_n;

    // R8
    halt_forces_low_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (state != GEN_RUN) |=> (!s_q.ls_n && !s_q.fs_n));

    // R4
    frame_sync_line0_chk: assert property (@(negedge clk) disable iff (!rst_n)
        ((state == GEN_RUN) && (line != '0)) |=> s_q.fs_n);

endmodule

// File: rtl/sync_tgen.sv
module sync_tgen
    import sync_tgen_pkg::*;
#(
    parameter int LINE_CLKS   = 1270,
    parameter int HS_WIDTH    = 32,
    parameter int FULL_LINES  = 792,
    parameter int DRAFT_LINES = 264,
    parameter int RD_LINE     = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          full_mode,
    input  logic                          sync_off,
    input  logic                          standby,
    output logic                          line_sync_n,
    output logic                          frame_sync_n,
    output logic [$clog2(FULL_LINES)-1:0] line_cnt,
    output logic [$clog2(LINE_CLKS)-1:0]  pix_cnt,
    output logic                          frame_start
);
    localparam int PIX_W  = $clog2(LINE_CLKS);
    localparam int LINE_W = $clog2(FULL_LINES);

    gen_state_e        gen_st;
    logic              run;
    logic              line_end;
    logic              full_act;
    logic [PIX_W-1:0]  pix;
    logic [LINE_W-1:0] line;

    always_comb begin
        gen_st = pick_state(standby, sync_off);
        run    = (gen_st == GEN_RUN);
    end

    sync_pix_ctr #(
        .LINE_CLKS (LINE_CLKS),
        .PIX_W     (PIX_W)
    ) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .pix      (pix),
        .line_end (line_end)
    );

    sync_line_ctr #(
        .FULL_LINES  (FULL_LINES),
        .DRAFT_LINES (DRAFT_LINES),
        .RD_LINE     (RD_LINE),
        .LINE_W      (LINE_W)
    ) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .line_end    (line_end),
        .full_req    (full_mode),
        .line        (line),
        .frame_start (frame_start),
        .full_act    (full_act)
    );

    sync_out_stage #(
        .HS_WIDTH (HS_WIDTH),
        .PIX_W    (PIX_W),
        .LINE_W   (LINE_W)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (gen_st),
        .pix          (pix),
        .line         (line),
        .line_sync_n  (line_sync_n),
        .frame_sync_n (frame_sync_n)
    );

    assign pix_cnt  = pix;
    assign line_cnt = line;

    // R7
    strobe_at_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (pix == '0));

    // R9
    standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> ((pix == '0) && (line == '0) && !frame_start));

    // R5
    draft_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_act && line_end && (line == LINE_W'(DRAFT_LINES - 1))) |=> (line == '0));

endmodule

// File: tb/tb_sync_tgen.sv
module tb_sync_tgen;
    localparam int LC  = 40;
    localparam int HS  = 4;
    localparam int FL  = 12;
    localparam int DL  = 4;
    localparam int RDL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_mode = 1'b0;
    logic sync_off = 1'b0;
    logic standby = 1'b0;
    logic line_sync_n, frame_sync_n, frame_start;
    logic [$clog2(FL)-1:0] line_cnt;
    logic [$clog2(LC)-1:0] pix_cnt;

    always #5 clk = ~clk;

    sync_tgen #(
        .LINE_CLKS (LC), .HS_WIDTH (HS), .FULL_LINES (FL),
        .DRAFT_LINES (DL), .RD_LINE (RDL)
    ) dut (
        .clk (clk), .rst_n (rst_n), .full_mode (full_mode),
        .sync_off (sync_off), .standby (standby),
        .line_sync_n (line_sync_n), .frame_sync_n (frame_sync_n),
        .line_cnt (line_cnt), .pix_cnt (pix_cnt), .frame_start (frame_start)
    );

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state
    int  m_pix = 0, m_line = 0;
    bit  m_full = 1'b0, m_fs = 1'b0;
    int  peak = 0, last_peak = -1;
    int  ls_low = 0, frs_low = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock: advance model at the rising edge, compare after the falling edge
    task automatic tick();
        bit halt;
        int last;
        @(posedge clk);
        halt = standby || sync_off;
        if (halt) begin
            m_pix = 0; m_line = 0; m_fs = 1'b0;
        end else begin
            last = m_full ? FL - 1 : DL - 1;
            m_fs = 1'b0;
            if (m_pix == LC - 1) begin
                m_pix = 0;
                if (m_line == RDL - 1) m_full = full_mode;
                if (m_line == last) begin m_line = 0; m_fs = 1'b1; end
                else m_line = m_line + 1;
            end else begin
                m_pix = m_pix + 1;
            end
        end
        @(negedge clk);
        #1;
        halt = standby || sync_off;
        chk("R2", "pix_cnt", int'(pix_cnt), m_pix);
        chk("R2", "line_cnt", int'(line_cnt), m_line);
        chk("R7", "frame_start", int'(frame_start), int'(m_fs));
        chk("R3", "line_sync_n", int'(line_sync_n), (!halt && m_pix >= HS) ? 1 : 0);
        chk("R4", "frame_sync_n", int'(frame_sync_n), (!halt && m_line != 0) ? 1 : 0);
        if (!line_sync_n) ls_low++;
        if (!frame_sync_n) frs_low++;
        if (frame_start) begin last_peak = peak; peak = 0; end
        if (int'(line_cnt) > peak) peak = int'(line_cnt);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_frame();
        int guard = 0;
        do begin tick(); guard++; end while (!frame_start && guard < 2000);
    endtask

    task automatic wait_pos(input int l, input int p);
        int guard = 0;
        while (!(int'(line_cnt) == l && int'(pix_cnt) == p) && guard < 2000) begin
            tick(); guard++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; full_mode = 1'b0; sync_off = 1'b0; standby = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "line_sync_n in reset", int'(line_sync_n), 0);
        chk("R1", "frame_sync_n in reset", int'(frame_sync_n), 0);
        chk("R1", "counters in reset", int'(pix_cnt) + int'(line_cnt), 0);
        chk("R1", "frame_start in reset", int'(frame_start), 0);
        m_pix = 0; m_line = 0; m_full = 1'b0; m_fs = 1'b0;
        peak = 0; last_peak = -1;
        rst_n = 1'b1;
    endtask

    task automatic t_line_frame_shape();
        t_reset();
        wait_frame();
        ls_low = 0; frs_low = 0;
        wait_frame();
        chk("R3", "line sync low clocks per draft frame", ls_low, HS * DL);
        chk("R4", "frame sync low clocks per frame", frs_low, LC);
        chk("R5", "draft frame peak line", last_peak, DL - 1);
        // R10: just after the rising edge into pixel 0 the old level still shows
        wait_pos(DL - 1, LC - 1);
        @(posedge clk);
        #1;
        chk("R10", "line_sync_n before falling edge", int'(line_sync_n), 1);
        m_pix = LC - 1; m_line = DL - 1;
        @(negedge clk);
        #1;
        chk("R10", "line_sync_n after falling edge", int'(line_sync_n), 0);
        m_pix = 0; m_line = 0; m_fs = 1'b1;
    endtask

    task automatic t_mode_switch();
        t_reset();
        wait_pos(RDL, 3);            // past the sampling wrap of this frame
        full_mode = 1'b1;
        wait_frame();
        chk("R6", "late request leaves frame draft", last_peak, DL - 1);
        wait_frame();
        chk("R5", "full frame peak line", last_peak, FL - 1);
        wait_pos(5, 10);
        full_mode = 1'b0;
        wait_frame();
        chk("R6", "draft request leaves full frame", last_peak, FL - 1);
        wait_frame();
        chk("R5", "back to draft frame", last_peak, DL - 1);
    endtask

    task automatic t_sync_off();
        t_reset();
        wait_pos(1, 10);
        sync_off = 1'b1;
        run_ticks(25);
        chk("R8", "pix held at 0", int'(pix_cnt), 0);
        chk("R8", "line held at 0", int'(line_cnt), 0);
        chk("R8", "line_sync_n held low", int'(line_sync_n), 0);
        chk("R8", "frame_sync_n held low", int'(frame_sync_n), 0);
        sync_off = 1'b0;
        tick();
        chk("R8", "restart pixel", int'(pix_cnt), 1);
        chk("R8", "restart line", int'(line_cnt), 0);
        run_ticks(60);
    endtask

    task automatic t_standby();
        t_reset();
        wait_pos(2, 20);
        standby = 1'b1;
        sync_off = 1'b1;
        run_ticks(10);
        chk("R9", "both low with standby", int'(line_sync_n) + int'(frame_sync_n), 0);
        standby = 1'b0;
        run_ticks(10);
        chk("R9", "still stopped with sync_off", int'(pix_cnt), 0);
        chk("R9", "line_sync_n still low", int'(line_sync_n), 0);
        sync_off = 1'b0;
        standby = 1'b1;
        run_ticks(5);
        chk("R9", "standby alone clears", int'(pix_cnt) + int'(line_cnt), 0);
        chk("R9", "standby alone forces low", int'(frame_sync_n), 0);
        standby = 1'b0;
        run_ticks(90);
    endtask

    initial begin
        t_line_frame_shape();
        t_mode_switch();
        t_sync_off();
        t_standby();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule